// File: doc/BRIEF.md
# Double-Buffered Random Word Streamer

This block generates 32-bit uniformly distributed unsigned integers with the MT19937 Mersenne Twister, which has a period of 2^19937 − 1. It writes them into two buffers in host memory that it fills in turn. Each buffer has a full/empty flag. The block fills a buffer only while that flag shows empty. It sends the words as bursts of 16 words (64 bytes) on a simple request/response write port. When every burst of a buffer has been acknowledged, it sets that buffer's flag to full and moves to the other buffer. The host drains a buffer at its own pace and hands it back by pulsing an empty-mark input. The two sides therefore run asynchronously. The block never signals the host; it only stalls while its next buffer is still full.

The 624-word generator state sits in an on-block array. That array is expanded from a 32-bit seed and then refreshed in place, one word for each output. A start pulse in the idle state captures the seed, both buffer base addresses and the buffer length in bursts. After that the block streams until reset.

Top module: `rng_pingpong_streamer`

## Requirements
- R1: While reset is asserted and after it is released, until a start pulse, both flags read empty (`flag_full` = 2'b00) and `req_valid` is low.
- R2: After a start with seed S, the accepted data words are exactly the MT19937 output for seed S, in order. For S = 5489 the first word is 3499211612 and the second is 581869302.
- R3: The stream stays equal to the MT19937 reference past word 624 and beyond, across every in-place refresh of the state.
- R4: Buffer A (flag bit 0, base `base_a`) is filled first, then buffer B (flag bit 1, base `base_b`), in strict alternation. At most one flag becomes full in any cycle.
- R5: No word is requested for a buffer whose flag is full. While both flags are full, `req_valid` stays low.
- R6: Burst k of a buffer carries the byte address base + 64·k on all 16 beats. `req_last` is high on the 16th beat only.
- R7: Once `req_valid` is high without `req_ready`, it stays high and `req_addr`, `req_data` and `req_last` hold until the beat is accepted. At most one word is consumed per accepted cycle.
- R8: A buffer's flag becomes full only after all of its words have been accepted and one `rsp_valid` has returned for each of its bursts. No request is outstanding in the cycle the flag rises.
- R9: A pulse on `mark_empty[b]` clears `flag_full[b]` by the next cycle. If the block sets the same flag in that cycle, the set takes priority.
- R10: A start pulse is acted on only in the idle state. A start while streaming leaves the seed, addresses, length and stream unchanged.
- R11: A buffer holds exactly `len_bursts` bursts (a value of 0 means 2^LW bursts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; captures seed and buffer setup when idle |
| seed | input | 32 | Generator seed |
| base_a | input | AW | Byte base address of buffer A |
| base_b | input | AW | Byte base address of buffer B |
| len_bursts | input | LW | Buffer length in 64-byte bursts |
| mark_empty | input | 2 | Host pulse: bit b marks buffer b empty |
| flag_full | output | 2 | Bit b high while buffer b is full |
| req_valid | output | 1 | Write beat valid |
| req_ready | input | 1 | Write beat accepted |
| req_addr | output | AW | Byte address of the current burst |
| req_data | output | 32 | Random word of this beat |
| req_last | output | 1 | Final beat of a burst |
| rsp_valid | input | 1 | One acknowledgement per completed burst |

## Verification
The assertions check the port rules on every cycle: a stalled beat holds, the address stays fixed inside a burst, no request is made while both flags are full, and a flag rises only with the request port idle, one flag at a time. The bench's scenarios are needed for the rest. They compare the full word stream against an independent MT19937 model, including words past the first state refresh. They also check the A/B order of flag rises, that a buffer is complete and acknowledged when its flag rises, clearing by the host, a start pulse that must be ignored mid-run, and two different buffer lengths under random back-pressure and random host delays.

// File: rtl/rngps_pkg.sv
package rngps_pkg;

  localparam int unsigned MT_N = 624;
  localparam int unsigned MT_M = 397;

  localparam logic [31:0] MT_MATRIX = 32'h9908B0DF;
  localparam logic [31:0] MT_MULT   = 32'd1812433253;
  localparam logic [31:0] MT_MASK_B = 32'h9D2C5680;
  localparam logic [31:0] MT_MASK_C = 32'hEFC60000;

  // Output tempering of one state word
  function automatic logic [31:0] mt_temper(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v >> 11);
    t = t ^ ((t << 7) & MT_MASK_B);
    t = t ^ ((t << 15) & MT_MASK_C);
    t = t ^ (t >> 18);
    return t;
  endfunction

  // Seed expansion: word k from word k-1
  function automatic logic [31:0] mt_seed_step(input logic [31:0] prev,
                                               input logic [31:0] k);
    return MT_MULT * (prev ^ (prev >> 30)) + k;
  endfunction

  typedef enum logic [2:0] {
    SCH_IDLE,
    SCH_SEED,
    SCH_WAIT,
    SCH_FILL,
    SCH_DRAIN
  } sched_e;

endpackage

// File: rtl/rngps_mt_core.sv
module rngps_mt_core
  import rngps_pkg::*;
#(
  parameter int unsigned N = MT_N,
  parameter int unsigned M = MT_M
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [31:0] seed,
  input  logic        take,
  output logic        rdy,
  output logic [31:0] word
);

  localparam int unsigned IW = $clog2(N);
  localparam logic [IW-1:0] LAST  = IW'(N - 1);
  localparam logic [IW:0]   M_OFF = (IW + 1)'(M);
  localparam logic [IW:0]   N_EXT = (IW + 1)'(N);

  logic [31:0]   st_mem [N];
  logic [IW-1:0] idx_q, idx_d;
  logic [31:0]   prev_q, prev_d;
  logic          seeding_q, seeding_d;
  logic          rdy_q, rdy_d;

  logic [IW-1:0] i_next, i_far;
  logic [IW:0]   far_sum;
  logic [31:0]   y_mix, twisted, init_val;
  logic          we;
  logic [IW-1:0] wa;
  logic [31:0]   wd;

  // Read side: current, next and far word of the in-place recurrence
  always_comb begin
    i_next   = (idx_q == LAST) ? '0 : idx_q + IW'(1);
    far_sum  = {1'b0, idx_q} + M_OFF;
    i_far    = (far_sum >= N_EXT) ? IW'(far_sum - N_EXT) : IW'(far_sum);
    y_mix    = {st_mem[idx_q][31], st_mem[i_next][30:0]};
    twisted  = st_mem[i_far] ^ (y_mix >> 1) ^ (y_mix[0] ? MT_MATRIX : 32'h0);
    init_val = mt_seed_step(prev_q, 32'(idx_q));
  end

  // Next state and the single write port
  always_comb begin
    idx_d     = idx_q;
    prev_d    = prev_q;
    seeding_d = seeding_q;
    rdy_d     = rdy_q;
    we        = 1'b0;
    wa        = idx_q;
    wd        = twisted;
    if (load) begin
      we        = 1'b1;
      wa        = '0;
      wd        = seed;
      prev_d    = seed;
      idx_d     = IW'(1);
      seeding_d = 1'b1;
      rdy_d     = 1'b0;
    end else if (seeding_q) begin
      we     = 1'b1;
      wd     = init_val;
      prev_d = init_val;
      if (idx_q == LAST) begin
        idx_d     = '0;
        seeding_d = 1'b0;
        rdy_d     = 1'b1;
      end else begin
        idx_d = i_next;
      end
    end else if (take && rdy_q) begin
      we    = 1'b1;
      idx_d = i_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q     <= '0;
      prev_q    <= '0;
      seeding_q <= 1'b0;
      rdy_q     <= 1'b0;
    end else begin
      idx_q     <= idx_d;
      prev_q    <= prev_d;
      seeding_q <= seeding_d;
      rdy_q     <= rdy_d;
    end
  end

  always_ff @(posedge clk) begin
    if (we) st_mem[wa] <= wd;
  end

  assign rdy  = rdy_q;
  assign word = mt_temper(twisted);

endmodule

// File: rtl/rngps_sched.sv
module rngps_sched
  import rngps_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 8,
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [LW-1:0] len_bursts,
  input  logic [1:0]    mark_empty,
  input  logic          gen_rdy,
  output logic          gen_load,
  output logic          gen_take,
  output logic [1:0]    flag_full,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic          req_last,
  input  logic          rsp_valid
);

  localparam int unsigned BBW = $clog2(BW);
  localparam int unsigned SH  = $clog2(BW * 4);
  localparam int unsigned OW  = LW + 1;
  localparam logic [BBW-1:0] BEAT_END = BBW'(BW - 1);

  sched_e        st_q, st_d;
  logic          cur_q, cur_d;
  logic [LW-1:0] burst_q, burst_d;
  logic [BBW-1:0] beat_q, beat_d;
  logic [OW-1:0] outst_q, outst_d;
  logic [1:0]    full_q, full_d;
  logic [AW-1:0] ba_q, bb_q;
  logic [LW-1:0] len_q;
  logic          cfg_en, acc, beat_end, burst_end;

  always_comb begin
    cfg_en    = (st_q == SCH_IDLE) && start;
    req_valid = (st_q == SCH_FILL) && gen_rdy;
    acc       = req_valid && req_ready;
    beat_end  = (beat_q == BEAT_END);
    burst_end = (burst_q == len_q - LW'(1));
    req_addr  = (cur_q ? bb_q : ba_q) + (AW'(burst_q) << SH);
    req_last  = beat_end;
    gen_take  = acc;
    gen_load  = cfg_en;
  end

  always_comb begin
    st_d    = st_q;
    cur_d   = cur_q;
    burst_d = burst_q;
    beat_d  = beat_q;
    outst_d = outst_q + OW'(acc && beat_end) - OW'(rsp_valid);
    full_d  = full_q & ~mark_empty;
    unique case (st_q)
      SCH_IDLE:  if (start) st_d = SCH_SEED;
      SCH_SEED:  if (gen_rdy) st_d = SCH_WAIT;
      SCH_WAIT: begin
        if (!full_q[cur_q]) begin
          st_d    = SCH_FILL;
          burst_d = '0;
          beat_d  = '0;
        end
      end
      SCH_FILL: begin
        if (acc) begin
          if (beat_end) begin
            beat_d = '0;
            if (burst_end) st_d = SCH_DRAIN;
            else burst_d = burst_q + LW'(1);
          end else begin
            beat_d = beat_q + BBW'(1);
          end
        end
      end
      SCH_DRAIN: begin
        if (outst_q == '0) begin
          full_d[cur_q] = 1'b1;  // set wins over a same-cycle host clear
          cur_d         = ~cur_q;
          st_d          = SCH_WAIT;
        end
      end
      default: st_d = SCH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SCH_IDLE;
      cur_q   <= 1'b0;
      burst_q <= '0;
      beat_q  <= '0;
      outst_q <= '0;
      full_q  <= 2'b00;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      burst_q <= burst_d;
      beat_q  <= beat_d;
      outst_q <= outst_d;
      full_q  <= full_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ba_q  <= '0;
      bb_q  <= '0;
      len_q <= '0;
    end else if (cfg_en) begin
      ba_q  <= base_a;
      bb_q  <= base_b;
      len_q <= len_bursts;
    end
  end

  assign flag_full = full_q;

endmodule

// File: rtl/rng_pingpong_streamer.sv
module rng_pingpong_streamer
  import rngps_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned LW = 8,
  parameter int unsigned BW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   seed,
  input  logic [AW-1:0] base_a,
  input  logic [AW-1:0] base_b,
  input  logic [LW-1:0] len_bursts,
  input  logic [1:0]    mark_empty,
  output logic [1:0]    flag_full,
  output logic          req_valid,
  input  logic          req_ready,
  output logic [AW-1:0] req_addr,
  output logic [31:0]   req_data,
  output logic          req_last,
  input  logic          rsp_valid
);

  logic gen_load, gen_take, gen_rdy;

  rngps_mt_core #(.N(MT_N), .M(MT_M)) u_core (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (gen_load),
    .seed  (seed),
    .take  (gen_take),
    .rdy   (gen_rdy),
    .word  (req_data)
  );

  rngps_sched #(.AW(AW), .LW(LW), .BW(BW)) u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .base_a     (base_a),
    .base_b     (base_b),
    .len_bursts (len_bursts),
    .mark_empty (mark_empty),
    .gen_rdy    (gen_rdy),
    .gen_load   (gen_load),
    .gen_take   (gen_take),
    .flag_full  (flag_full),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .req_last   (req_last),
    .rsp_valid  (rsp_valid)
  );

endmodule

// File: rtl/rng_pingpong_streamer_chk.sv
module rng_pingpong_streamer_chk #(
  parameter int unsigned AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    flag_full,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   req_data,
  input logic          req_last
);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_data) && $stable(req_last)));

  p_burst_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !req_last) |=> (req_valid && req_addr == $past(req_addr)));

  p_both_full_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_full == 2'b11) |-> !req_valid);

  p_full_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flag_full[0]) || $rose(flag_full[1])) |-> !req_valid);

  p_one_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flag_full & ~$past(flag_full)));

endmodule

bind rng_pingpong_streamer rng_pingpong_streamer_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flag_full (flag_full),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .req_data  (req_data),
  .req_last  (req_last)
);

// File: tb/sim_rng_pingpong_streamer.sv
module sim_rng_pingpong_streamer;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int LW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [31:0]   seed;
  logic [AW-1:0] base_a, base_b;
  logic [LW-1:0] len_bursts;
  logic [1:0]    mark_empty;
  logic [1:0]    flag_full;
  logic          req_valid, req_ready, req_last, rsp_valid;
  logic [AW-1:0] req_addr;
  logic [31:0]   req_data;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rng_pingpong_streamer #(.AW(AW), .LW(LW), .BW(16)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seed(seed),
    .base_a(base_a), .base_b(base_b), .len_bursts(len_bursts),
    .mark_empty(mark_empty), .flag_full(flag_full),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .req_last(req_last), .rsp_valid(rsp_valid)
  );

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d (0x%08h) expected %0d (0x%08h)",
               tag, what, act, act, exp, exp);
    end
  endtask

  // Independent reference: batch-refresh MT19937
  logic [31:0] ref_st [624];
  int          ref_pos;

  task automatic ref_seed(input logic [31:0] s);
    ref_st[0] = s;
    for (int i = 1; i < 624; i++)
      ref_st[i] = 32'd1812433253 * (ref_st[i-1] ^ (ref_st[i-1] >> 30)) + 32'(i);
    ref_pos = 624;
  endtask

  task automatic ref_next(output logic [31:0] w);
    logic [31:0] y;
    if (ref_pos >= 624) begin
      for (int k = 0; k < 624; k++) begin
        y = (ref_st[k] & 32'h80000000) | (ref_st[(k + 1) % 624] & 32'h7fffffff);
        ref_st[k] = ref_st[(k + 397) % 624] ^ (y >> 1) ^ (y[0] ? 32'h9908b0df : 32'h0);
      end
      ref_pos = 0;
    end
    y = ref_st[ref_pos];
    ref_pos++;
    y = y ^ (y >> 11);
    y = y ^ ((y << 7) & 32'h9d2c5680);
    y = y ^ ((y << 15) & 32'hefc60000);
    w = y ^ (y >> 18);
  endtask

  // Scoreboard queues (driver side pushes, monitor side pops)
  logic [31:0] q_addr[$];
  logic [31:0] q_data[$];
  bit          q_last[$];

  task automatic push_bufs(input int nb, input logic [31:0] a0, input logic [31:0] b0,
                           input int ln);
    logic [31:0] w;
    for (int k = 0; k < nb; k++)
      for (int bu = 0; bu < ln; bu++)
        for (int be = 0; be < 16; be++) begin
          ref_next(w);
          q_addr.push_back(((k % 2) ? b0 : a0) + 32'(bu * 64));
          q_data.push_back(w);
          q_last.push_back(be == 15);
        end
  endtask

  // Bench-side state
  int       bufs_done, exp_buf, words_in_buf, widx, pend, cur_len;
  int       cd [2];
  bit       mk_pend [2];
  logic [1:0] prev_flags;
  bit       start_req, held_v, scen1, long_first;
  logic [31:0] held_d;
  int       stall_cyc, stall_bad, restart_at, fail_mark;

  task automatic cycle();
    logic [1:0] rise;
    logic [31:0] ea, ed;
    bit el;
    string tag;
    @(negedge clk);
    for (int b = 0; b < 2; b++)
      if (mk_pend[b]) begin
        chk(flag_full[b] == 1'b0, "R9", "flag cleared after host mark", 32'(flag_full[b]), 0);
        mk_pend[b] = 0;
      end
    mark_empty = 2'b00;
    for (int b = 0; b < 2; b++)
      if (cd[b] > 0) begin
        cd[b]--;
        if (cd[b] == 0) begin
          mark_empty[b] = 1'b1;
          mk_pend[b] = 1;
        end
      end
    start = start_req;
    start_req = 0;
    if (pend > 0 && ($urandom % 3) == 0) begin
      rsp_valid = 1'b1;
      pend--;
    end else rsp_valid = 1'b0;
    req_ready = (($urandom % 4) != 0);  // random back-pressure for R7
    // R7: a stalled beat must reappear unchanged
    if (held_v) begin
      chk(req_valid && req_data == held_d, "R7", "stalled beat held", req_data, held_d);
      held_v = 0;
    end
    if (flag_full == 2'b11) begin
      stall_cyc++;
      if (req_valid) stall_bad++;
    end
    rise = flag_full & ~prev_flags;
    for (int b = 0; b < 2; b++)
      if (rise[b]) begin
        chk(b == exp_buf, "R4", "buffer order", 32'(b), 32'(exp_buf));
        chk(words_in_buf == cur_len * 16 && pend == 0, "R11",
            "words filled before flag rise (R8 acks drained)", 32'(words_in_buf), 32'(cur_len * 16));
        words_in_buf = 0;
        exp_buf ^= 1;
        cd[b] = (long_first && bufs_done == 0) ? 220 : 1 + int'($urandom % 30);
        bufs_done++;
      end
    prev_flags = flag_full;
    if (req_valid && !req_ready) begin
      held_v = 1;
      held_d = req_data;
    end
    if (req_valid && req_ready) begin
      if (q_data.size() == 0) begin
        chk(0, "R2", "unexpected extra word", req_data, 0);
      end else begin
        ea = q_addr.pop_front();
        ed = q_data.pop_front();
        el = q_last.pop_front();
        tag = (widx >= 624) ? "R3" : "R2";
        chk(req_data == ed, tag, $sformatf("word %0d", widx), req_data, ed);
        chk(req_addr == ea && req_last == el, "R6", $sformatf("addr/last of word %0d", widx),
            req_addr, ea);
        if (scen1 && widx == 0) chk(req_data == 32'd3499211612, "R2", "first word seed 5489", req_data, 32'd3499211612);
        if (scen1 && widx == 1) chk(req_data == 32'd581869302, "R2", "second word seed 5489", req_data, 32'd581869302);
      end
      widx++;
      words_in_buf++;
      if (req_last) pend++;
    end
    if (scen1 && bufs_done == restart_at && restart_at >= 0) begin
      // R10: start while running, with a different seed and base
      start_req = 1;
      seed = 32'd99;
      base_a = 32'h7777_0000;
      restart_at = -1;
      fail_mark = n_fail;
    end
  endtask

  task automatic reset_bench();
    bufs_done = 0; exp_buf = 0; words_in_buf = 0; widx = 0; pend = 0;
    cd[0] = 0; cd[1] = 0; mk_pend[0] = 0; mk_pend[1] = 0;
    prev_flags = 2'b00; start_req = 0; held_v = 0;
    stall_cyc = 0; stall_bad = 0; restart_at = -1;
    q_addr.delete(); q_data.delete(); q_last.delete();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; start = 1'b0; mark_empty = 2'b00; req_ready = 1'b0; rsp_valid = 1'b0;
    reset_bench();
    repeat (3) begin
      @(negedge clk);
      chk(flag_full == 2'b00, "R1", "flags in reset", 32'(flag_full), 0);
      chk(!req_valid, "R1", "no request in reset", 32'(req_valid), 0);
    end
    rst_n = 1'b1;
    repeat (4) begin
      @(negedge clk);
      chk(!req_valid && flag_full == 2'b00, "R1", "idle before start", 32'(req_valid), 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; seed = '0; base_a = '0; base_b = '0;
    len_bursts = '0; mark_empty = 2'b00; req_ready = 1'b0; rsp_valid = 1'b0;
    scen1 = 0; long_first = 0; fail_mark = 0;

    // Scenario 1: seed 5489, 4 bursts per buffer, 12 buffers (768 words)
    do_reset();
    scen1 = 1; long_first = 1; cur_len = 4;
    seed = 32'd5489; base_a = 32'h1000_0000; base_b = 32'h1800_0100; len_bursts = 8'd4;
    ref_seed(32'd5489);
    push_bufs(12, 32'h1000_0000, 32'h1800_0100, 4);
    start_req = 1;
    restart_at = 3;
    while (bufs_done < 12) cycle();
    chk(n_fail == fail_mark, "R10", "mismatches after start while running", 32'(n_fail - fail_mark), 0);
    chk(stall_cyc > 0, "R5", "both buffers full phase reached", 32'(stall_cyc), 1);
    chk(stall_bad == 0, "R5", "requests while both buffers full", 32'(stall_bad), 0);
    chk(q_data.size() == 0, "R2", "all expected words seen", 32'(q_data.size()), 0);

    // Scenario 2: reset, seed 1, one burst per buffer
    scen1 = 0; long_first = 0;
    do_reset();
    cur_len = 1;
    seed = 32'd1; base_a = 32'h2000_0000; base_b = 32'h3000_0040; len_bursts = 8'd1;
    ref_seed(32'd1);
    push_bufs(5, 32'h2000_0000, 32'h3000_0040, 1);
    start_req = 1;
    while (bufs_done < 5) cycle();
    chk(q_data.size() == 0, "R11", "one-burst buffers fully consumed", 32'(q_data.size()), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule